// File: doc/BRIEF.md
# Sleep Wake-Up Delay Sequencer

This block keeps a single 32-bit configuration word with one live bit, the fast-wake enable, and runs the exit from sleep. When the sequencer is in its run state, a sleep strobe puts it to sleep. A later wake event either waits a fixed supply-settling period with the core supply restarted, or goes straight on. After that the block pulses a resume-done signal to let the core continue.

With the enable bit at 0, the core supply enable is dropped for the whole of sleep. On wake it is raised again, and the block waits a parameterized number of cycles, which stands for 10 ms at the system clock, before it resumes. With the enable bit at 1, the supply stays on and the wait is skipped. The block samples the enable bit once, when sleep is entered. Sleep and wake never change the bit; only a hardware reset clears it.

Top module: `swk_seq_top`

## Requirements
- R1: A read strobe sampled at a clock edge loads reg_rdata at that edge. Bit 1 holds the fast-wake enable. Bit 0 and bits 31:2 always read 0, and writes to those bits have no effect. A write strobe loads the enable from reg_wdata bit 1.
- R2: A synchronous active-high reset clears the enable bit and reg_rdata to 0, puts the sequencer in run, and drives core_pwr_en to 1 and resume_done to 0.
- R3: A sleep_req sampled in run enters sleep at that edge. At the same edge core_pwr_en goes to 0 if the enable bit is 0, and stays 1 if it is 1. It keeps that value until a wake event arrives.
- R4: In slow mode (enable 0), take edge 0 as the edge that samples wake_evt while asleep. core_pwr_en returns to 1 at edge 0, and resume_done is 1 after edge SETTLE_CYCLES+1 and 0 after edge SETTLE_CYCLES.
- R5: In fast mode (enable 1), with edge 0 the edge that samples wake_evt while asleep, resume_done is 1 after edge 1 and 0 after edge 0.
- R6: resume_done is high for exactly one cycle, and only when the sequencer returns to run.
- R7: Sleep entry and wake-up never change the enable bit. Only a register write or a reset changes it.
- R8: wake_evt is ignored unless the sequencer is asleep. sleep_req is ignored unless the sequencer is in run, including during the settling wait.
- R9: The mode is captured at sleep entry. A write to the enable bit during sleep does not change the current wake-up, but it does apply to the next sleep.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| reg_wr | input | 1 | Register write strobe |
| reg_wdata | input | 32 | Register write data |
| reg_rd | input | 1 | Register read strobe |
| reg_rdata | output | 32 | Registered read data |
| sleep_req | input | 1 | Sleep entry strobe |
| wake_evt | input | 1 | Wake event |
| core_pwr_en | output | 1 | Core supply enable |
| resume_done | output | 1 | One-cycle pulse when the core may resume |

## Verification
The bench builds the block with SETTLE_CYCLES set to 20 in place of the 10 ms default. This keeps the settling wait short enough to check its exact end cycle, and to run several complete sleep cycles in both modes. The short wait also makes room to inject a sleep strobe in the middle of settling, and to write the enable bit during sleep, then confirm that the wake-up in progress keeps its captured mode.

// File: rtl/swk_pkg.sv
package swk_pkg;
  typedef enum logic [1:0] {
    ST_RUN    = 2'd0,
    ST_SLEEP  = 2'd1,
    ST_STAB   = 2'd2,
    ST_RESUME = 2'd3
  } swk_state_e;
endpackage

// File: rtl/swk_cfg_reg.sv
module swk_cfg_reg #(
  parameter int DATA_W   = 32,
  parameter int FAST_BIT = 1
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_en,
  input  logic [DATA_W-1:0] wr_data,
  input  logic              rd_en,
  output logic [DATA_W-1:0] rd_data,
  output logic              fast_en
);
  logic [DATA_W-1:0] word_c;

  // Only the enable position carries state; all other positions read zero.
  always_comb begin
    word_c           = '0;
    word_c[FAST_BIT] = fast_en;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      fast_en <= 1'b0;
      rd_data <= '0;
    end else begin
      if (wr_en) fast_en <= wr_data[FAST_BIT];
      if (rd_en) rd_data <= word_c;
    end
  end
endmodule

// File: rtl/swk_timer.sv
module swk_timer #(
  parameter int SETTLE_CYCLES = 2000000,
  parameter int CNT_W         = 21
) (
  input  logic clk,
  input  logic rst,
  input  logic load,
  output logic zero
);
  logic [CNT_W-1:0] cnt_q;

  always_ff @(posedge clk) begin
    if (rst)                 cnt_q <= '0;
    else if (load)           cnt_q <= CNT_W'(SETTLE_CYCLES - 1);
    else if (cnt_q != '0)    cnt_q <= cnt_q - 1'b1;
  end

  assign zero = (cnt_q == '0);
endmodule

// File: rtl/swk_fsm.sv
module swk_fsm
  import swk_pkg::*;
(
  input  logic       clk,
  input  logic       rst,
  input  logic       fast_en,
  input  logic       sleep_req,
  input  logic       wake_evt,
  input  logic       tmr_zero,
  output logic       tmr_load,
  output logic       core_pwr_en,
  output logic       resume_done,
  output swk_state_e state
);
  logic mode_q;

  assign tmr_load = (state == ST_SLEEP) && wake_evt && !mode_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      state       <= ST_RUN;
      core_pwr_en <= 1'b1;
      resume_done <= 1'b0;
      mode_q      <= 1'b0;
    end else begin
      resume_done <= 1'b0;
      case (state)
        ST_RUN: if (sleep_req) begin
          state       <= ST_SLEEP;
          mode_q      <= fast_en;
          core_pwr_en <= fast_en;
        end
        ST_SLEEP: if (wake_evt) begin
          core_pwr_en <= 1'b1;
          state       <= mode_q ? ST_RESUME : ST_STAB;
        end
        ST_STAB: if (tmr_zero) state <= ST_RESUME;
        default: begin
          state       <= ST_RUN;
          resume_done <= 1'b1;
        end
      endcase
    end
  end
endmodule

// File: rtl/swk_seq_top.sv
module swk_seq_top
  import swk_pkg::*;
#(
  parameter int DATA_W        = 32,
  parameter int FAST_BIT      = 1,
  parameter int SETTLE_CYCLES = 2000000
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              reg_wr,
  input  logic [DATA_W-1:0] reg_wdata,
  input  logic              reg_rd,
  output logic [DATA_W-1:0] reg_rdata,
  input  logic              sleep_req,
  input  logic              wake_evt,
  output logic              core_pwr_en,
  output logic              resume_done
);
  localparam int CNT_W = $clog2(SETTLE_CYCLES + 1);

  logic       fast_en;
  logic       tmr_load;
  logic       tmr_zero;
  swk_state_e state;

  swk_cfg_reg #(.DATA_W(DATA_W), .FAST_BIT(FAST_BIT)) u_cfg (
    .clk(clk), .rst(rst), .wr_en(reg_wr), .wr_data(reg_wdata),
    .rd_en(reg_rd), .rd_data(reg_rdata), .fast_en(fast_en)
  );

  swk_timer #(.SETTLE_CYCLES(SETTLE_CYCLES), .CNT_W(CNT_W)) u_tmr (
    .clk(clk), .rst(rst), .load(tmr_load), .zero(tmr_zero)
  );

  swk_fsm u_fsm (
    .clk(clk), .rst(rst), .fast_en(fast_en), .sleep_req(sleep_req),
    .wake_evt(wake_evt), .tmr_zero(tmr_zero), .tmr_load(tmr_load),
    .core_pwr_en(core_pwr_en), .resume_done(resume_done), .state(state)
  );
endmodule

// File: rtl/swk_seq_chk.sv
module swk_seq_chk
  import swk_pkg::*;
#(
  parameter int DATA_W   = 32,
  parameter int FAST_BIT = 1
) (
  input logic              clk,
  input logic              rst,
  input logic              reg_wr,
  input logic              reg_rd,
  input logic [DATA_W-1:0] reg_rdata,
  input logic              sleep_req,
  input logic              wake_evt,
  input logic              core_pwr_en,
  input logic              resume_done,
  input logic              fast_en,
  input swk_state_e        state
);
  localparam logic [DATA_W-1:0] RSVD_MASK = ~(DATA_W'(1) << FAST_BIT);

  assert_rsvd_zero_R1: assert property (@(posedge clk) disable iff (rst)
    $past(reg_rd) |-> ((reg_rdata & RSVD_MASK) == '0));

  assert_sleep_pwr_R3: assert property (@(posedge clk) disable iff (rst)
    (state == ST_RUN && sleep_req) |=> (core_pwr_en == $past(fast_en)));

  assert_pwr_low_only_sleep_R3: assert property (@(posedge clk) disable iff (rst)
    !core_pwr_en |-> (state == ST_SLEEP));

  assert_single_pulse_R6: assert property (@(posedge clk) disable iff (rst)
    resume_done |=> !resume_done);

  assert_done_in_run_R6: assert property (@(posedge clk) disable iff (rst)
    resume_done |-> (state == ST_RUN));

  assert_bit_kept_R7: assert property (@(posedge clk) disable iff (rst)
    !reg_wr |=> $stable(fast_en));

  assert_wake_ignored_R8: assert property (@(posedge clk) disable iff (rst)
    (state == ST_RUN && !sleep_req && wake_evt) |=> (state == ST_RUN));

  assert_sleep_ignored_R8: assert property (@(posedge clk) disable iff (rst)
    (state == ST_STAB) |=> (state != ST_SLEEP));
endmodule

bind swk_seq_top swk_seq_chk #(.DATA_W(DATA_W), .FAST_BIT(FAST_BIT)) u_chk (
  .clk(clk), .rst(rst), .reg_wr(reg_wr), .reg_rd(reg_rd), .reg_rdata(reg_rdata),
  .sleep_req(sleep_req), .wake_evt(wake_evt), .core_pwr_en(core_pwr_en),
  .resume_done(resume_done), .fast_en(fast_en), .state(state)
);

// File: tb/test_swk_seq_top.sv
`timescale 1ns/1ps
module test_swk_seq_top;
  localparam int SETTLE = 20;
  localparam int K_RD = 0, K_PWR = 1, K_DONE = 2;

  typedef struct {
    int          cyc;
    int          kind;
    logic [31:0] val;
    string       req;
  } exp_t;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        reg_wr = 1'b0;
  logic [31:0] reg_wdata = '0;
  logic        reg_rd = 1'b0;
  logic [31:0] reg_rdata;
  logic        sleep_req = 1'b0;
  logic        wake_evt = 1'b0;
  logic        core_pwr_en;
  logic        resume_done;

  int   cyc = 0;
  int   n_chk = 0;
  int   n_bad = 0;
  int   seen_done = 0;
  int   want_done = 0;
  bit   ended = 0;
  exp_t sb[$];

  always #2.5 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  swk_seq_top #(.SETTLE_CYCLES(SETTLE)) i_swk_seq_top (
    .clk(clk), .rst(rst), .reg_wr(reg_wr), .reg_wdata(reg_wdata),
    .reg_rd(reg_rd), .reg_rdata(reg_rdata), .sleep_req(sleep_req),
    .wake_evt(wake_evt), .core_pwr_en(core_pwr_en), .resume_done(resume_done)
  );

  // Monitor: compare every expected item due in this cycle.
  always @(negedge clk) begin
    logic [31:0] got;
    if (!rst && resume_done) seen_done++;
    for (int i = sb.size() - 1; i >= 0; i--) begin
      if (sb[i].cyc == cyc) begin
        case (sb[i].kind)
          K_RD:    got = reg_rdata;
          K_PWR:   got = {31'd0, core_pwr_en};
          default: got = {31'd0, resume_done};
        endcase
        n_chk++;
        if (got !== sb[i].val) begin
          n_bad++;
          $display("FAIL %s cycle %0d kind %0d: got %h expected %h",
                   sb[i].req, cyc, sb[i].kind, got, sb[i].val);
        end
        sb.delete(i);
      end
    end
  end

  task automatic push(int c, int k, logic [31:0] v, string r);
    exp_t e;
    e.cyc = c; e.kind = k; e.val = v; e.req = r;
    sb.push_back(e);
  endtask

  task automatic tick(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic do_write(logic [31:0] d);
    reg_wr = 1'b1; reg_wdata = d;
    tick(1);
    reg_wr = 1'b0; reg_wdata = '0;
  endtask

  task automatic do_read(logic [31:0] e, string r);
    reg_rd = 1'b1;
    push(cyc + 1, K_RD, e, r);
    tick(1);
    reg_rd = 1'b0;
  endtask

  task automatic go_sleep(logic pwr, string r);
    sleep_req = 1'b1;
    push(cyc + 1, K_PWR, {31'd0, pwr}, r);
    tick(1);
    sleep_req = 1'b0;
  endtask

  task automatic stay(int n, logic pwr, string r);
    for (int i = 0; i < n; i++) begin
      push(cyc + 1, K_PWR, {31'd0, pwr}, r);
      tick(1);
    end
  endtask

  // Wake sampled at edge cyc+1 (edge 0 of the requirement).
  task automatic go_wake(logic fast);
    int n0 = cyc;
    wake_evt = 1'b1;
    if (fast) begin
      push(n0 + 1, K_DONE, 32'd0, "R5");
      push(n0 + 1, K_PWR, 32'd1, "R5");
      push(n0 + 2, K_DONE, 32'd1, "R5");
      push(n0 + 3, K_DONE, 32'd0, "R6");
    end else begin
      push(n0 + 1, K_PWR, 32'd1, "R4");
      push(n0 + SETTLE, K_PWR, 32'd1, "R4");
      push(n0 + SETTLE + 1, K_DONE, 32'd0, "R4");
      push(n0 + SETTLE + 2, K_DONE, 32'd1, "R4");
      push(n0 + SETTLE + 3, K_DONE, 32'd0, "R6");
    end
    want_done++;
    tick(1);
    wake_evt = 1'b0;
  endtask

  task automatic finish_run(bit timeout);
    if (ended) return;
    ended = 1;
    if (timeout) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog: got timeout expected completion");
    end
    n_chk++;
    if (sb.size() != 0) begin
      n_bad++;
      $display("FAIL R6 pending items: got %0d expected 0", sb.size());
    end
    n_chk++;
    if (seen_done != want_done) begin
      n_bad++;
      $display("FAIL R6/R8 resume pulses: got %0d expected %0d", seen_done, want_done);
    end
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  endtask

  initial begin
    #(200000 * 5.0);
    finish_run(1);
  end

  initial begin
    tick(3);
    rst = 1'b0;
    push(cyc + 1, K_PWR, 32'd1, "R2");
    push(cyc + 1, K_DONE, 32'd0, "R2");
    push(cyc + 1, K_RD, 32'd0, "R2");
    tick(2);
    do_read(32'd0, "R2");

    // R1: reserved bits read 0, only bit 1 stored.
    do_write(32'hFFFF_FFFF);
    do_read(32'h0000_0002, "R1");
    do_write(32'hFFFF_FFFD);
    do_read(32'h0000_0000, "R1");

    // Slow sleep cycle, enable = 0 (R3, R4).
    go_sleep(1'b0, "R3");
    stay(6, 1'b0, "R3");
    go_wake(1'b0);
    tick(SETTLE + 5);
    do_read(32'd0, "R7");

    // Fast sleep cycle, enable = 1 (R3, R5, R7).
    do_write(32'h0000_0002);
    go_sleep(1'b1, "R3");
    stay(5, 1'b1, "R3");
    go_wake(1'b1);
    tick(5);
    do_read(32'h0000_0002, "R7");

    // R8: wake in run ignored; sleep during settling ignored.
    wake_evt = 1'b1;
    tick(1);
    wake_evt = 1'b0;
    stay(5, 1'b1, "R8");
    do_write(32'd0);
    go_sleep(1'b0, "R8");
    stay(3, 1'b0, "R8");
    go_wake(1'b0);
    tick(4);
    sleep_req = 1'b1;
    tick(1);
    sleep_req = 1'b0;
    tick(SETTLE + 5);
    push(cyc + 1, K_PWR, 32'd1, "R8");
    tick(2);

    // R9: mode captured at entry; write during sleep applies next time.
    go_sleep(1'b0, "R9");
    do_write(32'h0000_0002);
    stay(3, 1'b0, "R9");
    go_wake(1'b0);
    tick(SETTLE + 5);
    do_read(32'h0000_0002, "R9");
    go_sleep(1'b1, "R9");
    stay(3, 1'b1, "R9");
    go_wake(1'b1);
    tick(5);

    // R2: reset clears the enable bit.
    rst = 1'b1;
    tick(2);
    rst = 1'b0;
    do_read(32'd0, "R2");
    tick(5);
    finish_run(0);
  end
endmodule